// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block drives a time-multiplexed digit display from a small on-block character store. It holds sixteen 8-bit entries and walks a scan index through them. For the digit currently selected, it shows the high half of the entry on one 4-bit output port and the low half on a second 4-bit port. The scan index is an output too, so external digit drivers select the matching digit in the same cycle that the port data belongs to it.

A single host write port carries both character data and commands, told apart by a select input. Each character write goes to an internal write pointer, which then advances and wraps from the last entry to entry 0. The commands do the following:
- choose a 16-digit or an 8-digit scan,
- set the prescaler divisor that sets the scan speed,
- load the write pointer,
- mask either nibble port on its own,
- blank the whole display.

At each change of digit, the blank-display output is raised for one prescaler tick and both ports are held at zero. This gives a guard interval against ghosting.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: After reset the scan index is 0, the blank-display output is 1, both ports are 0, the scan covers 16 digits, the write pointer is 0, the prescaler divisor is 7 and every entry holds 0x00.
- R2: A prescaler tick occurs once every D+1 clocks, where D is the divisor. The scan index advances once every 4 ticks, that is every 4*(D+1) clocks. A command with opcode 3'b001 in host_data[7:5] loads D from host_data[4:0].
- R3: In 16-digit mode the scan index counts 0..15 and then wraps to 0. A command with opcode 3'b000 selects 8-digit mode when host_data[0] is 1 and 16-digit mode when it is 0. In 8-digit mode the index counts 0..7, and an index above 7 goes to 0 at its next step.
- R4: When no blanking applies, port_a equals bits 7:4 and port_b equals bits 3:0 of the entry selected by the scan index, in the same cycle as that index.
- R5: During the first tick period of every digit, disp_blank is 1 and both ports are 0.
- R6: A data write (host_is_cmd = 0) stores host_data into the entry at the write pointer. The pointer then increments and wraps from 15 to 0.
- R7: A command with opcode 3'b100 loads the write pointer from host_data[3:0].
- R8: A command with opcode 3'b101 sets two masks: host_data[1] = 1 forces port_a to 0, and host_data[0] = 1 forces port_b to 0. The two masks act independently and hold until the next such command.
- R9: A command with opcode 3'b110 and host_data[0] = 1 holds disp_blank at 1 and both ports at 0. The same command with host_data[0] = 0 releases this blanking.
- R10: Commands with opcodes 3'b010, 3'b011 and 3'b111 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one write per cycle it is high |
| host_is_cmd | input | 1 | 1: host_data is a command, 0: character data |
| host_data | input | 8 | Character byte or command (opcode in bits 7:5) |
| scan_line | output | 4 | Index of the digit being shown |
| port_a | output | 4 | High nibble of the selected entry |
| port_b | output | 4 | Low nibble of the selected entry |
| disp_blank | output | 1 | Blank-display indication |

## Verification
The assertions assume that reset is held for at least two clocks, so that every past value they read comes from a reset state. They also assume that each host write lasts a single cycle and carries a defined data value. The bench drives the host inputs only at falling edges, and each write lasts exactly one cycle.

Random divisors are kept at 5 or below, so that many digit changes, wraps and mode switches occur within the run. The directed cases make the writes wrap the pointer and change the mode while the index is above 7. The properties about the index are built to hold when the divisor changes part way through a tick.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    // command opcodes carried in host_data[7:5]
    localparam logic [2:0] OP_MODE   = 3'b000;
    localparam logic [2:0] OP_DIV    = 3'b001;
    localparam logic [2:0] OP_PTR    = 3'b100;
    localparam logic [2:0] OP_MASK   = 3'b101;
    localparam logic [2:0] OP_DBLANK = 3'b110;

    typedef struct packed {
        logic [2:0] op;
        logic [4:0] arg;
    } cmd_t;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } entry_t;

    typedef struct packed {
        logic mode8;
        logic mask_a;
        logic mask_b;
        logic dblank;
    } dispcfg_t;

    function automatic int unsigned wrap_inc(int unsigned cur, int unsigned last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/drc_prescaler.sv
module drc_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    // a divisor lowered below the running count ends the period at once
    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drc_scan_seq.sv
module drc_scan_seq
    import drc_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SCAN_TICKS = 4,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int SUB_W     = (SCAN_TICKS > 2) ? $clog2(SCAN_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mode8,
    output logic [ADDR_W-1:0] scan,
    output logic              guard
);
    localparam int unsigned LAST_FULL = DEPTH - 1;
    localparam int unsigned LAST_HALF = DEPTH / 2 - 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SCAN_TICKS - 1);

    logic [SUB_W-1:0]  sub;
    logic [ADDR_W-1:0] scan_nx;
    int unsigned       last;

    always_comb begin
        last    = mode8 ? LAST_HALF : LAST_FULL;
        scan_nx = ADDR_W'(wrap_inc(int'(scan), last));
    end

    assign guard = (sub == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub  <= '0;
            scan <= '0;
        end else if (tick) begin
            if (sub == SUB_LAST) begin
                sub  <= '0;
                scan <= scan_nx;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/drc_host_ctrl.sv
module drc_host_ctrl
    import drc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int PRE_W   = 5,
    parameter int RST_DIV = 7,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_is_cmd,
    input  logic [BYTE_W-1:0] host_data,
    output dispcfg_t          cfg,
    output logic [PRE_W-1:0]  div,
    output logic [ADDR_W-1:0] wptr,
    output logic              ram_we
);
    cmd_t cmd;
    logic cmd_we;

    assign cmd    = cmd_t'(host_data);
    assign cmd_we = host_we && host_is_cmd;
    assign ram_we = host_we && !host_is_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            div  <= PRE_W'(RST_DIV);
            wptr <= '0;
        end else begin
            if (ram_we) begin
                wptr <= wptr + 1'b1;
            end
            if (cmd_we) begin
                case (cmd.op)
                    OP_MODE:   cfg.mode8  <= cmd.arg[0];
                    OP_DIV:    div        <= PRE_W'(cmd.arg);
                    OP_PTR:    wptr       <= ADDR_W'(cmd.arg);
                    OP_MASK: begin
                        cfg.mask_a <= cmd.arg[1];
                        cfg.mask_b <= cmd.arg[0];
                    end
                    OP_DBLANK: cfg.dblank <= cmd.arg[0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/drc_disp_ram.sv
module drc_disp_ram
    import drc_pkg::*;
#(
    parameter int DEPTH   = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output entry_t            rdata
);
    entry_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (we && waddr == ADDR_W'(i)) begin
                mem[i] <= entry_t'(wdata);
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
    import drc_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int PRE_W      = 5,
    parameter int RST_DIV    = 7,
    parameter int SCAN_TICKS = 4,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_is_cmd,
    input  logic [7:0]        host_data,
    output logic [ADDR_W-1:0] scan_line,
    output logic [3:0]        port_a,
    output logic [3:0]        port_b,
    output logic              disp_blank
);
    dispcfg_t          cfg;
    logic [PRE_W-1:0]  div;
    logic [ADDR_W-1:0] wptr;
    logic              ram_we;
    logic              tick;
    logic              guard;
    logic              mode8;
    logic              mask_a;
    logic              mask_b;
    entry_t            cur;

    drc_host_ctrl #(.DEPTH(DEPTH), .PRE_W(PRE_W), .RST_DIV(RST_DIV)) u_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_is_cmd(host_is_cmd),
        .host_data(host_data), .cfg(cfg), .div(div), .wptr(wptr), .ram_we(ram_we)
    );

    drc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .div(div), .tick(tick)
    );

    drc_scan_seq #(.DEPTH(DEPTH), .SCAN_TICKS(SCAN_TICKS)) u_scan (
        .clk(clk), .rst(rst), .tick(tick), .mode8(mode8),
        .scan(scan_line), .guard(guard)
    );

    drc_disp_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(wptr), .wdata(host_data),
        .raddr(scan_line), .rdata(cur)
    );

    assign mode8  = cfg.mode8;
    assign mask_a = cfg.mask_a;
    assign mask_b = cfg.mask_b;

    always_comb begin
        disp_blank = guard || cfg.dblank;
        port_a     = (disp_blank || mask_a) ? '0 : cur.hi;
        port_b     = (disp_blank || mask_b) ? '0 : cur.lo;
    end
endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] scan_line,
    input logic [3:0]        port_a,
    input logic [3:0]        port_b,
    input logic              disp_blank,
    input logic              mode8,
    input logic              mask_a,
    input logic              mask_b,
    input logic              ram_we,
    input logic [ADDR_W-1:0] wptr
);
    // R5
    guard_on_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(scan_line) |-> disp_blank);

    // R3
    scan_order_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(scan_line) |-> (scan_line == ADDR_W'($past(scan_line) + 1'b1) || scan_line == '0));

    // R3
    half_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mode8 && $past(mode8) && $past(scan_line) <= ADDR_W'(DEPTH/2 - 1)) |-> scan_line <= ADDR_W'(DEPTH/2 - 1));

    // R5
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        disp_blank |-> (port_a == 4'h0 && port_b == 4'h0));

    // R8
    mask_a_chk: assert property (@(posedge clk) disable iff (rst)
        mask_a |-> port_a == 4'h0);

    // R8
    mask_b_chk: assert property (@(posedge clk) disable iff (rst)
        mask_b |-> port_b == 4'h0);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ram_we) |-> wptr == ADDR_W'($past(wptr) + 1'b1));
endmodule

bind disp_refresh_ctrl drc_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .scan_line(scan_line), .port_a(port_a), .port_b(port_b),
    .disp_blank(disp_blank), .mode8(mode8), .mask_a(mask_a), .mask_b(mask_b),
    .ram_we(ram_we), .wptr(wptr)
);

// File: tb/disp_refresh_ctrl_tb.sv
module disp_refresh_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic       host_is_cmd = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic [3:0] scan_line;
    logic [3:0] port_a;
    logic [3:0] port_b;
    logic       disp_blank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_refresh_ctrl u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_is_cmd(host_is_cmd),
        .host_data(host_data), .scan_line(scan_line), .port_a(port_a),
        .port_b(port_b), .disp_blank(disp_blank)
    );

    // reference state built from the requirements
    logic [7:0] m_ram [16];
    logic [4:0] m_cnt, m_div;
    logic [1:0] m_sub;
    logic [3:0] m_scan, m_ptr;
    logic       m_mode8, m_ma, m_mb, m_db;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_ram[i] <= 8'h00;
            m_cnt <= 0; m_div <= 5'd7; m_sub <= 0; m_scan <= 0; m_ptr <= 0;
            m_mode8 <= 0; m_ma <= 0; m_mb <= 0; m_db <= 0;
        end else begin
            if (m_cnt >= m_div) begin
                m_cnt <= 0;
                if (m_sub == 2'(TICKS - 1)) begin
                    m_sub  <= 0;
                    m_scan <= (m_scan >= (m_mode8 ? 4'd7 : 4'd15)) ? 4'd0 : m_scan + 4'd1;
                end else m_sub <= m_sub + 2'd1;
            end else m_cnt <= m_cnt + 5'd1;
            if (host_we && !host_is_cmd) begin
                m_ram[m_ptr] <= host_data;
                m_ptr <= m_ptr + 4'd1;
            end
            if (host_we && host_is_cmd) begin
                case (host_data[7:5])
                    3'b000: m_mode8 <= host_data[0];
                    3'b001: m_div   <= host_data[4:0];
                    3'b100: m_ptr   <= host_data[3:0];
                    3'b101: begin m_ma <= host_data[1]; m_mb <= host_data[0]; end
                    3'b110: m_db    <= host_data[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_blank();
        return (m_sub == 2'd0) || m_db;
    endfunction

    function automatic logic [3:0] exp_nib(input bit hi);
        logic [7:0] e;
        e = m_ram[m_scan];
        if (exp_blank()) return 4'h0;
        if (hi) return m_ma ? 4'h0 : e[7:4];
        return m_mb ? 4'h0 : e[3:0];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2/R3", "scan_line", int'(scan_line), int'(m_scan));
            chk("R5/R9", "disp_blank", int'(disp_blank), int'(exp_blank()));
            chk("R4/R8", "port_a", int'(port_a), int'(exp_nib(1'b1)));
            chk("R4/R8", "port_b", int'(port_b), int'(exp_nib(1'b0)));
        end
    end

    task automatic host(input bit is_cmd, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_is_cmd = is_cmd; host_data = d;
        @(negedge clk);
        host_we = 1'b0; host_is_cmd = 1'b0;
    endtask

    task automatic wait_shown(input logic [3:0] idx);
        int guard_cnt = 0;
        do begin
            @(negedge clk);
            guard_cnt++;
        end while (!(scan_line == idx && !disp_blank) && guard_cnt < 5000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "scan_line", int'(scan_line), 0);
        chk("R1", "disp_blank", int'(disp_blank), 1);
        chk("R1", "port_a", int'(port_a), 0);
        chk("R1", "port_b", int'(port_b), 0);
        rst = 1'b0;

        // R1: entries read back 0 with default 16-digit scan and divisor 7
        wait_shown(4'd15);
        chk("R1", "entry 15 port_a", int'(port_a), 0);

        // R2: digit period with divisor 2 is 4*3 = 12 clocks
        host(1'b1, 8'b001_00010);
        @(negedge clk iff scan_line != m_scan || 1'b1);
        begin
            logic [3:0] s;
            s = scan_line;
            while (scan_line == s) @(negedge clk);
            s = scan_line; t0 = $time;
            while (scan_line == s) @(negedge clk);
            t1 = $time;
            chk("R2", "digit period clocks", (t1 - t0) / CLK_PERIOD, 12);
        end

        // R6: pointer wraps 15 -> 0; seventeenth write lands in entry 0
        host(1'b1, 8'h80);
        for (int i = 0; i < 17; i++) host(1'b0, (i == 16) ? 8'hA5 : 8'(8'h11 * i + 8'h11));
        wait_shown(4'd0);
        chk("R6", "entry0 port_a", int'(port_a), 4'hA);
        chk("R6", "entry0 port_b", int'(port_b), 4'h5);
        wait_shown(4'd1);
        chk("R6", "entry1 port_b", int'(port_b), 4'h2);

        // R7: pointer load then write
        host(1'b1, 8'h83);
        host(1'b0, 8'h7C);
        wait_shown(4'd3);
        chk("R7", "entry3 port_a", int'(port_a), 4'h7);
        chk("R4", "entry3 port_b", int'(port_b), 4'hC);

        // R8: independent masks
        host(1'b1, 8'hA2);
        wait_shown(4'd3);
        chk("R8", "masked port_a", int'(port_a), 0);
        chk("R8", "unmasked port_b", int'(port_b), 4'hC);
        host(1'b1, 8'hA1);
        wait_shown(4'd3);
        chk("R8", "unmasked port_a", int'(port_a), 4'h7);
        chk("R8", "masked port_b", int'(port_b), 0);
        host(1'b1, 8'hA0);

        // R9: whole-display blank
        host(1'b1, 8'hC1);
        repeat (30) @(negedge clk);
        chk("R9", "disp_blank held", int'(disp_blank), 1);
        chk("R9", "port_a blanked", int'(port_a), 0);
        host(1'b1, 8'hC0);

        // R10: unused opcodes leave state alone
        host(1'b1, 8'h5F); host(1'b1, 8'h7F); host(1'b1, 8'hFF);
        wait_shown(4'd3);
        chk("R10", "port_a after unused ops", int'(port_a), 4'h7);
        chk("R10", "port_b after unused ops", int'(port_b), 4'hC);
        chk("R10", "scan still 16-digit range", int'(m_mode8), 0);

        // R3: switch to 8-digit while index above 7, then back
        wait_shown(4'd12);
        host(1'b1, 8'h01);
        begin
            int gc = 0;
            while (scan_line >= 4'd12 && gc < 500) begin @(negedge clk); gc++; end
        end
        chk("R3", "index after switch to 8-digit", int'(scan_line), 0);
        repeat (200) begin
            @(negedge clk);
            if (scan_line > 4'd7) chk("R3", "8-digit range", int'(scan_line), 7);
        end
        host(1'b1, 8'h00);

        // random traffic checked cycle by cycle
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 12) host(1'b0, 8'($urandom));
            else if (r < 20) begin
                logic [2:0] op;
                logic [4:0] arg;
                op  = 3'($urandom);
                arg = 5'($urandom);
                if (op == 3'b001) arg = 5'(arg % 6);
                if (op == 3'b110 && ($urandom % 4) != 0) arg[0] = 1'b0;
                host(1'b1, {op, arg});
            end else @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule